// File: doc/BRIEF.md
# Eight-Source Hardware Interrupt Controller

This block gathers eight peripheral condition lines and a low-battery detect line for a small 16-bit processor. It turns them into a maskable interrupt request and a separate non-maskable request. Three sources (0, 2 and 3) are level sensitive: they request for as long as their condition is true and enabled. The other five (1, 4, 5, 6 and 7) are edge sensitive: a false-to-true change of the condition sets a latch, and the latch holds until firmware clears it.

Firmware uses a byte-wide register port with five addresses. These hold an aligned vector base, a per-source enable mask, a read-only pending view, a write-one-to-clear acknowledge and a low-battery NMI arm bit. When the processor raises its acknowledge handshake, the block returns the vector number of the highest-numbered pending source. That number is the base with the source index in its low three bits.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset, the vector base, enable mask, edge latches and NMI arm bit are all zero, so `irq_req` and `nmi_req` are low and every register reads 0x00.
- R2: Address 0 holds the vector base. A write keeps bits 7..3 only, so a read returns the written value with bits 2..0 forced to zero.
- R3: Level sources 0, 2 and 3 show a 1 in the pending register (address 2) in the same cycle that their condition and enable bit are both 1. They hold no state of their own.
- R4: Writing 1s to the acknowledge register (address 3) for a level source whose condition is still true leaves its pending bit at 1.
- R5: An edge source sets its pending bit in the cycle after the clock edge that first samples its condition high while the source is enabled. The bit stays set after the condition falls.
- R6: The enable register (address 1) masks sources bit by bit. A disabled source never shows pending and never raises `irq_req`. Clearing an enable bit discards that source's latch from the next cycle on, and an edge that arrives while the source is disabled is lost.
- R7: Writing the acknowledge register clears the latch of each edge source whose data bit is 1. Bits written as 0 leave their latches unchanged, and the acknowledge register reads as 0x00.
- R8: When a new edge and an acknowledge of the same source fall on the same clock edge, the latch ends up set.
- R9: `irq_req` is high exactly when the pending register is non-zero.
- R10: While `irq_ack` is high, `irq_vector` equals the base with the index of the highest-numbered pending source in bits 2..0 (index 0 when none is pending). While `irq_ack` is low, `irq_vector` is 0x00.
- R11: Bit 4 of address 4 arms the low-battery NMI and is the only bit stored there. While the block is armed, a rising edge of `batt_low` gives a one-cycle `nmi_req` pulse in the cycle after the sampling clock edge. The pulse does not depend on the enable mask.
- R12: Writes to the pending register (address 2) change no state. Reads of unused addresses 5..7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_cond | input | 8 | Peripheral condition lines, one per source |
| batt_low | input | 1 | Low-battery detect |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Maskable interrupt request |
| irq_ack | input | 1 | Processor acknowledge handshake |
| irq_vector | output | 8 | Vector number, valid while `irq_ack` is high |
| nmi_req | output | 1 | Non-maskable request pulse |

## Verification
A wrong latch or mask value shows up at once in the pending register read and in `irq_req`. It also shows up in the vector returned during the next acknowledge, because a stale or missing latch moves the highest pending index. Edge-detect state that is off by one cycle moves the appearance of a pending bit, or of the NMI pulse, by exactly one clock. For that reason the reference model compares every output on every cycle and catches any such slip on the first cycle where it differs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC  = 8;
    localparam int IDXW  = $clog2(NSRC);
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int NMI_ARM_BIT = 4;

    // 1 = level-sensitive source, 0 = edge-latched source
    localparam logic [NSRC-1:0] LEVEL_KIND = 8'b0000_1101;

    typedef enum logic [AW-1:0] {
        RA_BASE  = 3'd0,
        RA_MASK  = 3'd1,
        RA_PEND  = 3'd2,
        RA_CLEAR = 3'd3,
        RA_NMI   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [DW-1:IDXW] base_hi;
        logic [NSRC-1:0]  mask;
        logic             nmi_arm;
    } cfg_t;

    typedef struct packed {
        logic            hit;
        logic [IDXW-1:0] idx;
    } pick_t;

    // highest-numbered set bit wins
    function automatic pick_t pick_highest(input logic [NSRC-1:0] v);
        pick_t r;
        r = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = IDXW'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [AW-1:0]        reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    input  logic [NSRC-1:0]      pending,
    output cfg_t                 cfg,
    output logic [NSRC-1:0]      clear_bits,
    output logic [DW-1:0]        reg_rdata
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_BASE: cfg_q.base_hi <= reg_wdata[DW-1:IDXW];
                RA_MASK: cfg_q.mask    <= reg_wdata[NSRC-1:0];
                RA_NMI:  cfg_q.nmi_arm <= reg_wdata[NMI_ARM_BIT];
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;

    always_comb begin
        clear_bits = '0;
        if (reg_wr && reg_addr == RA_CLEAR) begin
            clear_bits = reg_wdata[NSRC-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_BASE: reg_rdata = {cfg_q.base_hi, {IDXW{1'b0}}};
            RA_MASK: reg_rdata = cfg_q.mask;
            RA_PEND: reg_rdata = pending;
            RA_NMI:  reg_rdata[NMI_ARM_BIT] = cfg_q.nmi_arm;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
#(
    parameter int              N     = NSRC,
    parameter logic [N-1:0]    LEVEL = LEVEL_KIND
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  cond,
    input  logic [N-1:0]  mask,
    input  logic [N-1:0]  clear_bits,
    output logic [N-1:0]  pending
);

    for (genvar i = 0; i < N; i++) begin : g_src
        if (LEVEL[i]) begin : g_level
            // follows the condition; nothing to acknowledge
            assign pending[i] = cond[i] & mask[i];
        end else begin : g_edge
            logic cond_q;
            logic latch_q;
            logic rise;

            assign rise = cond[i] & ~cond_q & mask[i];

            always_ff @(posedge clk) begin
                if (rst) begin
                    cond_q  <= 1'b0;
                    latch_q <= 1'b0;
                end else begin
                    cond_q  <= cond[i];
                    // new edge beats a same-cycle clear; disabling drops the latch
                    latch_q <= rise | (latch_q & ~clear_bits[i] & mask[i]);
                end
            end

            assign pending[i] = latch_q & mask[i];
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]   pending,
    input  logic [DW-1:IDXW]  base_hi,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [DW-1:0]     irq_vector
);

    pick_t win;

    assign win        = pick_highest(pending);
    assign irq_req    = win.hit;
    assign irq_vector = irq_ack ? {base_hi, win.idx} : '0;

endmodule

// File: rtl/irqc_nmi.sv
module irqc_nmi (
    input  logic clk,
    input  logic rst,
    input  logic batt_low,
    input  logic arm,
    output logic nmi_req
);

    logic batt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            batt_q  <= 1'b0;
            nmi_req <= 1'b0;
        end else begin
            batt_q  <= batt_low;
            nmi_req <= arm & batt_low & ~batt_q;
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      src_cond,
    input  logic                 batt_low,
    input  logic                 reg_wr,
    input  logic [AW-1:0]        reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 irq_req,
    input  logic                 irq_ack,
    output logic [DW-1:0]        irq_vector,
    output logic                 nmi_req
);

    cfg_t            cfg;
    logic [NSRC-1:0] clear_bits;
    logic [NSRC-1:0] pending;

    irqc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .pending    (pending),
        .cfg        (cfg),
        .clear_bits (clear_bits),
        .reg_rdata  (reg_rdata)
    );

    irqc_pending #(
        .N     (NSRC),
        .LEVEL (LEVEL_KIND)
    ) u_pending (
        .clk        (clk),
        .rst        (rst),
        .cond       (src_cond),
        .mask       (cfg.mask),
        .clear_bits (clear_bits),
        .pending    (pending)
    );

    irqc_prio u_prio (
        .pending    (pending),
        .base_hi    (cfg.base_hi),
        .irq_ack    (irq_ack),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );

    irqc_nmi u_nmi (
        .clk      (clk),
        .rst      (rst),
        .batt_low (batt_low),
        .arm      (cfg.nmi_arm),
        .nmi_req  (nmi_req)
    );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [NSRC-1:0]     src_cond,
    input logic                batt_low,
    input logic                reg_wr,
    input logic [AW-1:0]       reg_addr,
    input logic [DW-1:0]       reg_wdata,
    input logic                irq_req,
    input logic                irq_ack,
    input logic [DW-1:0]       irq_vector,
    input logic                nmi_req,
    input logic [NSRC-1:0]     pending,
    input logic [NSRC-1:0]     mask,
    input logic [DW-1:IDXW]    base_hi
);

    logic ack_wr;
    assign ack_wr = reg_wr && (reg_addr == RA_CLEAR);

    // R6: nothing disabled is ever pending
    a_r6_masked_silent: assert property (@(posedge clk) disable iff (rst)
        (pending & ~mask) == '0);

    // R10: the vector names the highest pending source under the base
    a_r10_highest_wins: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |->
            (((pending >> irq_vector[IDXW-1:0]) == NSRC'(1)) && (irq_vector[DW-1:IDXW] == base_hi)));

    a_r10_idle_vector: assert property (@(posedge clk) disable iff (rst)
        !irq_ack |-> (irq_vector == '0));

    // R11: a single-cycle pulse that follows a rising edge of the detect line
    a_r11_nmi_one_cycle: assert property (@(posedge clk) disable iff (rst)
        nmi_req |=> !nmi_req);

    a_r11_nmi_after_rise: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> ($past(batt_low) && !$past(batt_low, 2)));

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        if (LEVEL_KIND[i]) begin : g_lvl
            // R4: level request survives an acknowledge while its condition holds
            a_r4_level_holds: assert property (@(posedge clk) disable iff (rst)
                (src_cond[i] && mask[i]) |-> pending[i]);
        end else begin : g_edg
            // R5: an edge latch persists until cleared or disabled
            a_r5_edge_persists: assert property (@(posedge clk) disable iff (rst)
                (pending[i] && !(ack_wr && reg_wdata[i])) |=> (pending[i] || !mask[i]));
        end
    end

endmodule

bind irqc_top irqc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_cond   (src_cond),
    .batt_low   (batt_low),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq_req    (irq_req),
    .irq_ack    (irq_ack),
    .irq_vector (irq_vector),
    .nmi_req    (nmi_req),
    .pending    (pending),
    .mask       (cfg.mask),
    .base_hi    (cfg.base_hi)
);

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] src_cond = '0;
    logic       batt_low = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic       irq_ack = 1'b0;
    logic [7:0] irq_vector;
    logic       nmi_req;

    always #2 clk = ~clk;

    irqc_top u_irqc_top (
        .clk(clk), .rst(rst), .src_cond(src_cond), .batt_low(batt_low),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_ack(irq_ack),
        .irq_vector(irq_vector), .nmi_req(nmi_req)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int  m_base, m_mask, m_latch, m_condq, m_arm, m_battq, m_nmi;
    localparam int LVL = 'h0D;

    task automatic chk(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", t, act, exp, $time);
        end
    endtask

    function automatic int exp_pending();
        return (int'(src_cond) & m_mask & LVL) | (m_latch & m_mask);
    endfunction

    function automatic int exp_rdata();
        case (reg_addr)
            3'd0: return m_base;
            3'd1: return m_mask;
            3'd2: return exp_pending();
            3'd4: return m_arm ? 'h10 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_vector();
        int p, idx;
        p = exp_pending();
        idx = 0;
        for (int i = 0; i < 8; i++) if (p[i]) idx = i;
        return irq_ack ? (m_base | idx) : 0;
    endfunction

    task automatic model_clock();
        int rise, clr;
        if (rst) begin
            m_base = 0; m_mask = 0; m_latch = 0; m_condq = 0;
            m_arm = 0; m_battq = 0; m_nmi = 0;
        end else begin
            rise = int'(src_cond) & ~m_condq & m_mask & ~LVL & 'hFF;
            clr  = (reg_wr && reg_addr == 3'd3) ? int'(reg_wdata) : 0;
            m_nmi = (m_arm != 0 && batt_low && m_battq == 0) ? 1 : 0;
            m_latch = (rise | (m_latch & ~clr & m_mask)) & ~LVL & 'hFF;
            m_condq = int'(src_cond);
            m_battq = int'(batt_low);
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_base = int'(reg_wdata) & 'hF8;
                    3'd1: m_mask = int'(reg_wdata);
                    3'd4: m_arm  = int'(reg_wdata[4]);
                    default: ;
                endcase
            end
        end
    endtask

    // compare all outputs mid-cycle, then advance the model at the edge
    task automatic cyc();
        #1;
        if (!rst) begin
            chk({tag, " R9 irq_req"},     int'(irq_req), (exp_pending() != 0) ? 1 : 0);
            chk({tag, " R10 irq_vector"}, int'(irq_vector), exp_vector());
            chk({tag, " R11 nmi_req"},    int'(nmi_req), m_nmi);
            chk({tag, " reg_rdata"},      int'(reg_rdata), exp_rdata());
        end
        @(posedge clk);
        model_clock();
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        cyc();
    endtask

    task automatic rd(int a);
        reg_addr = 3'(a);
        cyc();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        for (int i = 0; i < 3; i++) cyc();
        rst = 1'b0;
        chk("R1 irq_req after reset", int'(irq_req), 0);
        chk("R1 nmi_req after reset", int'(nmi_req), 0);
        for (int a = 0; a < 8; a++) rd(a);

        tag = "R2";                       // low three base bits dropped
        wr(0, 'hA7); rd(0);
        tag = "R6";
        wr(1, 'hFF);

        tag = "R3";                       // level sources follow condition
        src_cond = 8'h05; rd(2);
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        tag = "R4";                       // ack cannot clear a held level
        wr(3, 'h0D); rd(2); rd(2);
        src_cond = 8'h00; rd(2);

        tag = "R5";                       // edge latches
        src_cond = 8'h10; rd(2);
        src_cond = 8'h00; rd(2); rd(2);
        tag = "R10";
        src_cond = 8'h82; cyc(); src_cond = 8'h00;
        irq_ack = 1'b1; cyc(); cyc(); irq_ack = 1'b0;

        tag = "R7";                       // write-one-to-clear
        wr(3, 'h80); rd(2);
        wr(3, 'h00); rd(2); rd(3);
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;

        tag = "R8";                       // edge beats same-cycle clear
        wr(3, 'h12); rd(2);
        src_cond = 8'h20; wr(3, 'h20); rd(2);
        src_cond = 8'h00; rd(2);

        tag = "R12";                      // pending register is read-only
        wr(2, 'h00); rd(2); rd(5); rd(7);

        tag = "R6";                       // mask drops latches and blocks edges
        src_cond = 8'h04; wr(1, 'h00); rd(2);
        src_cond = 8'h44; rd(2);
        wr(1, 'hFF); rd(2);
        src_cond = 8'h00; rd(2);
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;

        tag = "R11";                      // NMI arm and pulse
        batt_low = 1'b1; rd(4); batt_low = 1'b0; rd(4);
        wr(4, 'hFF); rd(4);
        wr(1, 'h00);
        batt_low = 1'b1; cyc(); cyc(); cyc();
        batt_low = 1'b0; cyc();
        batt_low = 1'b1; cyc(); cyc();
        batt_low = 1'b0;
        wr(4, 'h00); batt_low = 1'b1; cyc(); cyc(); batt_low = 1'b0;

        tag = "R9";                       // mixed random traffic
        for (int n = 0; n < 2000; n++) begin
            src_cond = 8'($urandom);
            batt_low = 1'($urandom);
            irq_ack  = 1'($urandom);
            reg_addr = 3'($urandom);
            reg_wdata = 8'($urandom);
            reg_wr   = ($urandom % 4) == 0;
            cyc();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule